// File: doc/BRIEF.md
# Near-Memory Accumulate Write Unit

This unit sits beside one memory bank and takes partial-sum updates from a compute array. The array sends only the increment for an output element. The unit reads the stored value, adds the increment and writes the sum back. The array therefore issues no reads of intermediate outputs, and output traffic across the link is half of what array-side accumulation would need.

A request is either an accumulate, which adds the increment, or a set, which overwrites the element. A set is used, for example, to load a bias before accumulation starts. The pipeline takes one request per cycle, and updates that land on the same address back to back are all counted because sums still in flight are forwarded.

Each request chooses its own arithmetic mode: wrap-around or saturating two's-complement. A sticky flag records any signed overflow of an accumulate. A plain read port returns final results two cycles after it is presented. While that port is used, the request port deasserts ready, so that the bank's read side serves only one operation in each cycle.

Top module: `nma_accum_unit`

## Requirements
- R1: After synchronous reset, req_ready is 1, rd_resp_valid is 0 and ovf_sticky is 0.
- R2: An accepted request with req_op = 0 (accumulate) adds req_delta to the stored word at req_addr, and one request can be accepted every cycle.
- R3: An accepted request with req_op = 1 (set) writes req_delta to req_addr unchanged, and it never changes ovf_sticky.
- R4: Accumulates to the same address 1, 2 or 3 cycles apart all take effect, and no increment is lost.
- R5: A plain read sampled at a clock edge gives rd_resp_valid = 1 and rd_resp_data two edges later. The data includes every request accepted before the read.
- R6: When rd_valid is 1, req_ready is 0 and a request presented in that cycle is ignored.
- R7: With req_sat = 0, an accumulate wraps modulo 2^16 in two's complement.
- R8: With req_sat = 1, an accumulate that overflows clamps to +32767 (positive overflow) or to -32768 (negative overflow). An accumulate that does not overflow gives the exact sum.
- R9: ovf_sticky goes to 1 after any accumulate whose signed sum overflows, in either mode, and stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Update request present |
| req_ready | output | 1 | Unit can accept an update this cycle |
| req_op | input | 1 | 0 accumulate, 1 set |
| req_sat | input | 1 | 1 saturating, 0 wrap-around arithmetic |
| req_addr | input | 6 | Target element address |
| req_delta | input | 16 | Increment, or value to set |
| rd_valid | input | 1 | Plain read request |
| rd_addr | input | 6 | Plain read address |
| rd_resp_valid | output | 1 | Read result valid |
| rd_resp_data | output | 16 | Read result |
| ovf_sticky | output | 1 | Sticky accumulate-overflow flag |

## Verification
The embedded properties check the following on every cycle:
- A read is answered exactly two cycles later.
- The overflow flag never clears on its own.
- A set or a read leaves that flag alone.
- No update enters the pipeline in a cycle taken by a read.
- A saturated result keeps the sign of the stored operand.

The forwarding cases, where the same address is hit at distances of one, two and three cycles, can only be shown by the scoreboard scenarios. The same is true of the exact wrap and clamp values and of an ignored request during a read. In those scenarios every read result is compared with a model of the bank.

// File: rtl/nma_pkg.sv
package nma_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        OP_ACC = 2'd0,
        OP_SET = 2'd1,
        OP_RD  = 2'd2
    } op_e;

    typedef struct packed {
        logic  vld;
        op_e   op;
        logic  sat;
        addr_t addr;
        word_t data;
    } issue_t;

    typedef struct packed {
        logic  vld;
        op_e   op;
        addr_t addr;
        word_t val;
    } result_t;

    typedef struct packed {
        logic  vld;
        addr_t addr;
        word_t val;
    } retire_t;

    function automatic logic writes_bank(op_e op);
        return op != OP_RD;
    endfunction
endpackage

// File: rtl/nma_bank.sv
module nma_bank #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] mem [WORDS];

    // read returns the pre-write value when both ports hit one address
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/nma_fwd.sv
module nma_fwd #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic [AW-1:0] look_addr,
    input  logic          near_vld,
    input  logic [AW-1:0] near_addr,
    input  logic [DW-1:0] near_val,
    input  logic          far_vld,
    input  logic [AW-1:0] far_addr,
    input  logic [DW-1:0] far_val,
    input  logic [DW-1:0] bank_q,
    output logic [DW-1:0] base
);
    logic near_hit, far_hit;

    assign near_hit = near_vld && (near_addr == look_addr);
    assign far_hit  = far_vld  && (far_addr  == look_addr);

    // youngest pending value wins
    always_comb begin
        if (near_hit)
            base = near_val;
        else if (far_hit)
            base = far_val;
        else
            base = bank_q;
    end
endmodule

// File: rtl/nma_addsat.sv
module nma_addsat #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sat,
    output logic [DW-1:0] res,
    output logic          ovf
);
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] wide;

    assign wide = {a[DW-1], a} + {b[DW-1], b};
    assign ovf  = wide[DW] != wide[DW-1];

    always_comb begin
        if (sat && ovf)
            res = wide[DW] ? NEG_MIN : POS_MAX;
        else
            res = wide[DW-1:0];
    end

    always_comb begin
        if (sat && ovf)
            AST_SAT_SIGN: assert (res[DW-1] == a[DW-1]); // R8
    end
endmodule

// File: rtl/nma_accum_unit.sv
module nma_accum_unit
    import nma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic              req_sat,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_delta,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_resp_valid,
    output logic [DATA_W-1:0] rd_resp_data,
    output logic              ovf_sticky
);
    issue_t  st_issue;
    result_t st_result;
    retire_t st_retire;

    logic    req_fire;
    addr_t   bank_raddr;
    word_t   bank_q;
    word_t   base_val;
    word_t   sum_val;
    logic    sum_ovf;
    word_t   next_val;
    logic    bank_we;

    // read port owns the bank read side whenever it is active
    assign req_ready  = !rd_valid;
    assign req_fire   = req_valid && req_ready;
    assign bank_raddr = rd_valid ? rd_addr : req_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_issue <= '0;
        end else if (rd_valid) begin
            st_issue <= '{vld: 1'b1, op: OP_RD, sat: 1'b0, addr: rd_addr, data: '0};
        end else if (req_fire) begin
            st_issue <= '{vld: 1'b1, op: (req_op ? OP_SET : OP_ACC), sat: req_sat,
                          addr: req_addr, data: req_delta};
        end else begin
            st_issue <= '0;
        end
    end

    nma_bank #(.AW(ADDR_W), .DW(DATA_W)) u_bank (
        .clk   (clk),
        .we    (bank_we),
        .waddr (st_result.addr),
        .wdata (st_result.val),
        .raddr (bank_raddr),
        .rdata (bank_q)
    );

    nma_fwd #(.AW(ADDR_W), .DW(DATA_W)) u_fwd (
        .look_addr (st_issue.addr),
        .near_vld  (bank_we),
        .near_addr (st_result.addr),
        .near_val  (st_result.val),
        .far_vld   (st_retire.vld),
        .far_addr  (st_retire.addr),
        .far_val   (st_retire.val),
        .bank_q    (bank_q),
        .base      (base_val)
    );

    nma_addsat #(.DW(DATA_W)) u_add (
        .a   (base_val),
        .b   (st_issue.data),
        .sat (st_issue.sat),
        .res (sum_val),
        .ovf (sum_ovf)
    );

    always_comb begin
        unique case (st_issue.op)
            OP_SET:  next_val = st_issue.data;
            OP_RD:   next_val = base_val;
            default: next_val = sum_val;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_result  <= '0;
            ovf_sticky <= 1'b0;
        end else begin
            st_result  <= '{vld: st_issue.vld, op: st_issue.op,
                           addr: st_issue.addr, val: next_val};
            if (st_issue.vld && st_issue.op == OP_ACC && sum_ovf)
                ovf_sticky <= 1'b1;
        end
    end

    assign bank_we = st_result.vld && writes_bank(st_result.op);

    always_ff @(posedge clk) begin
        if (rst)
            st_retire <= '0;
        else
            st_retire <= '{vld: bank_we, addr: st_result.addr, val: st_result.val};
    end

    assign rd_resp_valid = st_result.vld && st_result.op == OP_RD;
    assign rd_resp_data  = st_result.val;

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ##2 rd_resp_valid); // R5

    AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
        ovf_sticky |=> ovf_sticky); // R9

    AST_SET_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (st_issue.vld && st_issue.op != OP_ACC) |=> $stable(ovf_sticky)); // R3

    AST_READ_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !(st_issue.vld && st_issue.op != OP_RD)); // R6
endmodule

// File: tb/nma_accum_unit_test.sv
module nma_accum_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic        req_sat = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [15:0] req_delta = '0;
    logic        rd_valid = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        rd_resp_valid;
    logic [15:0] rd_resp_data;
    logic        ovf_sticky;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [15:0] mdl [64];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    nma_accum_unit uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_sat(req_sat), .req_addr(req_addr), .req_delta(req_delta),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_resp_valid(rd_resp_valid),
        .rd_resp_data(rd_resp_data), .ovf_sticky(ovf_sticky)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_add(input logic [15:0] old, input logic [15:0] d,
                                              input bit sat, output bit ov);
        logic [16:0] w;
        w  = {old[15], old} + {d[15], d};
        ov = w[16] != w[15];
        if (sat && ov)
            return w[16] ? 16'h8000 : 16'h7fff;
        return w[15:0];
    endfunction

    task automatic send(input bit setop, input int a, input int d, input bit sat);
        bit ov;
        req_valid = 1'b1; req_op = setop; req_addr = 6'(a);
        req_delta = 16'(d); req_sat = sat; rd_valid = 1'b0;
        if (setop)
            mdl[a] = 16'(d);
        else
            mdl[a] = model_add(mdl[a], 16'(d), sat, ov);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic rd(input int a, input string tag, input bit with_req);
        rd_valid = 1'b1; rd_addr = 6'(a);
        if (with_req) begin
            req_valid = 1'b1; req_op = 1'b0; req_addr = 6'(a); req_delta = 16'd100;
        end
        exp_q.push_back(mdl[a]);
        tag_q.push_back(tag);
        #1;
        chk({tag, " ready"}, {15'd0, req_ready}, 16'd0);
        @(negedge clk);
        rd_valid = 1'b0; req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && rd_resp_valid) begin
            if (exp_q.size() == 0) begin
                compared++; mismatched++;
                $display("FAIL R5 unexpected response actual=%0h expected=none", rd_resp_data);
            end else begin
                chk(tag_q.pop_front(), rd_resp_data, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ready", {15'd0, req_ready}, 16'd1);
        chk("R1 resp_valid", {15'd0, rd_resp_valid}, 16'd0);
        chk("R1 ovf", {15'd0, ovf_sticky}, 16'd0);

        // R3 set initial values
        for (int i = 0; i < 16; i++) send(1'b1, i, i * 3 - 7, 1'b0);
        for (int i = 0; i < 16; i += 3) rd(i, "R3 set value", 1'b0);

        // R2 back-to-back accumulates to distinct addresses
        for (int i = 0; i < 8; i++) send(1'b0, i, 50 + i, 1'b0);
        for (int i = 0; i < 8; i++) rd(i, "R2 accumulate", 1'b0);

        // R4 distance 1
        for (int i = 0; i < 5; i++) send(1'b0, 9, 11 * (i + 1), 1'b0);
        rd(9, "R4 distance1", 1'b0);
        // R4 distance 2
        for (int i = 0; i < 6; i++) send(1'b0, 10 + (i % 2), -5 - i, 1'b0);
        rd(10, "R4 distance2 a", 1'b0);
        rd(11, "R4 distance2 b", 1'b0);
        // R4 distance 3
        for (int i = 0; i < 9; i++) send(1'b0, 12 + (i % 3), 7, 1'b0);
        rd(12, "R4 distance3 a", 1'b0);
        rd(13, "R4 distance3 b", 1'b0);
        rd(14, "R4 distance3 c", 1'b0);
        // R3 set between accumulates on one address
        send(1'b0, 15, 40, 1'b0);
        send(1'b1, 15, 1000, 1'b0);
        send(1'b0, 15, 3, 1'b0);
        rd(15, "R3 set amid accumulates", 1'b0);
        // R5 read right after an accumulate, gaps in between
        send(1'b0, 4, -9, 1'b0);
        idle(1);
        rd(4, "R5 read after gap", 1'b0);
        idle(3);
        chk("R9 no overflow yet", {15'd0, ovf_sticky}, 16'd0);

        // R6 request presented during a read is ignored
        rd(5, "R6 read with request", 1'b1);
        rd(5, "R6 value unchanged", 1'b0);

        // R7 wrap
        send(1'b1, 20, 32767, 1'b0);
        send(1'b0, 20, 1, 1'b0);
        rd(20, "R7 wrap positive", 1'b0);
        idle(3);
        chk("R9 ovf set by wrap", {15'd0, ovf_sticky}, 16'd1);
        send(1'b1, 21, -32768, 1'b0);
        send(1'b0, 21, -2, 1'b0);
        rd(21, "R7 wrap negative", 1'b0);

        // R8 saturate
        send(1'b1, 22, 32000, 1'b0);
        send(1'b0, 22, 1000, 1'b1);
        rd(22, "R8 clamp high", 1'b0);
        send(1'b1, 23, -32000, 1'b0);
        send(1'b0, 23, -1000, 1'b1);
        rd(23, "R8 clamp low", 1'b0);
        send(1'b0, 24, 0, 1'b0);
        send(1'b1, 24, 100, 1'b0);
        send(1'b0, 24, -300, 1'b1);
        rd(24, "R8 exact sum", 1'b0);

        // R9 stays set
        for (int i = 0; i < 4; i++) send(1'b1, 30 + i, i, 1'b0);
        idle(4);
        chk("R9 ovf sticky", {15'd0, ovf_sticky}, 16'd1);
        idle(4);
        chk("R5 all responses seen", 16'(exp_q.size()), 16'd0);
        finish_run();
    end
endmodule